// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the feedback divider of a frequency synthesizer loop. It runs on the divided RF clock and emits one single-cycle pulse for every N input cycles. The pulse goes to the phase detector. The ratio is built from three stages in cascade:

- a fixed divide-by-4 stage;
- a dual-modulus prescaler that divides by P or P+1;
- a swallow counter A and a main counter B, which together decide how many prescaler periods use the larger modulus.

The total ratio is N = 4(B·P + A).

Configuration is the prescaler select and the A and B values. It is captured into shadow registers only at the boundary between output periods, so a change never produces a malformed period. Values that break the pairing rules are flagged and rejected. A hold input and a power-down input both park every counter in its load state. Counting restarts cleanly when they are released.

Top module: `fb_swallow_div`

## Requirements
- R1: While running, consecutive rising edges of `div_o` are exactly N = 4·(B·P + A) clock cycles apart.
- R2: The prescaler select `psel_i` maps to the lower modulus P as follows: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64.
- R3: While `hold_i` is high, `div_o` stays low. After release, the first pulse appears after exactly N cycles, counted from the first clock edge with `hold_i` low, using the A, B and P present at release.
- R4: `pdn_i` behaves like `hold_i`: no pulses while high, and a first pulse exactly N cycles after it falls.
- R5: A change to `psel_i`, `a_val_i` or `b_val_i` during a period does not alter that period. The new ratio applies from the next period on.
- R6: A value set with B < 2 or B < A (A zero-extended) drives `cfg_err_o` high one cycle later, and the flag falls one cycle after a legal set returns. Illegal values are never loaded, so the previous ratio continues.
- R7: Every N/4 = n ≥ P·(P−1) is reachable with B = n div P and A = n mod P. For P = 8 and n from 56 to 66, each gives period 4·n.
- R8: After reset, `div_o` and `cfg_err_o` are low. The counters start from a default setting of A = 0, B = 2 and P = 8, so with `hold_i` low the first pulse comes after 64 cycles.
- R9: `div_o` is high for exactly one cycle per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divider input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | Hold all counters in load state |
| pdn_i | input | 1 | Power-down; forces load state |
| psel_i | input | 2 | Prescaler modulus select |
| a_val_i | input | 6 | Swallow count A |
| b_val_i | input | 13 | Main count B |
| div_o | output | 1 | Divided feedback pulse |
| cfg_err_o | output | 1 | Illegal A/B setting presented |

## Verification
The hardest situation to reach from the ports is a change of configuration in the middle of a period, or while the counters are parked. This matters because the divider must finish the running period on the old ratio, or restart on the values present at release. The stimulus waits for an output pulse, which marks a reload boundary, and changes the inputs on that same cycle. The bench then expects one interval at the old ratio followed by intervals at the new one. Hold and power-down are asserted a fixed number of cycles into a period, and the inputs are rewritten while parked.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int unsigned A_W_DEF      = 6;
  localparam int unsigned B_W_DEF      = 13;
  localparam int unsigned PSEL_W_DEF   = 2;
  localparam int unsigned PLOG_MIN_DEF = 3;   // smallest P = 2**3
  localparam int unsigned QDIV_W_DEF   = 2;   // fixed /4 stage

  typedef enum logic [1:0] {
    PS_8  = 2'd0,
    PS_16 = 2'd1,
    PS_32 = 2'd2,
    PS_64 = 2'd3
  } psel_e;
endpackage

// File: rtl/fbdiv_quarter.sv
module fbdiv_quarter #(
  parameter int unsigned QW = fbdiv_pkg::QDIV_W_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  logic [QW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == {QW{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + QW'(1);
  end
endmodule

// File: rtl/fbdiv_dualmod.sv
module fbdiv_dualmod #(
  parameter int unsigned PLOG_MIN = fbdiv_pkg::PLOG_MIN_DEF,
  parameter int unsigned PSEL_W   = fbdiv_pkg::PSEL_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [PSEL_W-1:0] psel_i,
  input  logic              hi_i,     // divide by P+1 this period
  output logic              ptick_o
);
  localparam int unsigned NSEL = 1 << PSEL_W;
  localparam int unsigned CW   = PLOG_MIN + NSEL;

  logic [CW-1:0] base_term [NSEL];
  logic [CW-1:0] term;
  logic [CW-1:0] cnt_q;

  for (genvar g = 0; g < NSEL; g++) begin : g_term
    assign base_term[g] = CW'((1 << (PLOG_MIN + g)) - 1);
  end

  assign term    = base_term[psel_i] + CW'(hi_i);
  assign ptick_o = tick_i && (cnt_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= ptick_o ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow #(
  parameter int unsigned A_W      = fbdiv_pkg::A_W_DEF,
  parameter int unsigned B_W      = fbdiv_pkg::B_W_DEF,
  parameter int unsigned PSEL_W   = fbdiv_pkg::PSEL_W_DEF,
  parameter int unsigned RST_A    = 0,
  parameter int unsigned RST_B    = 2,
  parameter int unsigned RST_PSEL = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              ptick_i,
  input  logic [PSEL_W-1:0] psel_i,
  input  logic [A_W-1:0]    a_i,
  input  logic [B_W-1:0]    b_i,
  output logic              hi_o,
  output logic              reload_o,
  output logic [PSEL_W-1:0] psel_sh_o,
  output logic [A_W-1:0]    a_sh_o,
  output logic [B_W-1:0]    b_sh_o,
  output logic              cfg_err_o
);
  logic [A_W-1:0]    a_sh_q, acnt_q, nxt_a;
  logic [B_W-1:0]    b_sh_q, bcnt_q, nxt_b;
  logic [PSEL_W-1:0] p_sh_q, nxt_p;
  logic              legal, load, err_q;

  assign legal = (b_i >= B_W'(2)) && (b_i >= B_W'(a_i));
  assign nxt_a = legal ? a_i    : a_sh_q;
  assign nxt_b = legal ? b_i    : b_sh_q;
  assign nxt_p = legal ? psel_i : p_sh_q;

  assign reload_o = ptick_i && (bcnt_q == '0);
  assign load     = !run_i || reload_o;
  assign hi_o     = (acnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_sh_q <= A_W'(RST_A);
      b_sh_q <= B_W'(RST_B);
      p_sh_q <= PSEL_W'(RST_PSEL);
      acnt_q <= A_W'(RST_A);
      bcnt_q <= B_W'(RST_B - 1);
    end else if (load) begin
      a_sh_q <= nxt_a;
      b_sh_q <= nxt_b;
      p_sh_q <= nxt_p;
      acnt_q <= nxt_a;
      bcnt_q <= nxt_b - B_W'(1);
    end else if (ptick_i) begin
      bcnt_q <= bcnt_q - B_W'(1);
      if (acnt_q != '0) acnt_q <= acnt_q - A_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= !legal;
  end

  assign psel_sh_o = p_sh_q;
  assign a_sh_o    = a_sh_q;
  assign b_sh_o    = b_sh_q;
  assign cfg_err_o = err_q;
endmodule

// File: rtl/fb_swallow_div.sv
module fb_swallow_div #(
  parameter int unsigned A_W      = fbdiv_pkg::A_W_DEF,
  parameter int unsigned B_W      = fbdiv_pkg::B_W_DEF,
  parameter int unsigned PSEL_W   = fbdiv_pkg::PSEL_W_DEF,
  parameter int unsigned PLOG_MIN = fbdiv_pkg::PLOG_MIN_DEF,
  parameter int unsigned QW       = fbdiv_pkg::QDIV_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              pdn_i,
  input  logic [PSEL_W-1:0] psel_i,
  input  logic [A_W-1:0]    a_val_i,
  input  logic [B_W-1:0]    b_val_i,
  output logic              div_o,
  output logic              cfg_err_o
);
  logic              run_w, qtick_w, ptick_w, hi_w, reload_w;
  logic [PSEL_W-1:0] psel_sh_w;
  logic [A_W-1:0]    a_sh_w;
  logic [B_W-1:0]    b_sh_w;
  logic              div_q;

  assign run_w = !hold_i && !pdn_i;

  fbdiv_quarter #(.QW(QW)) u_quarter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_w),
    .tick_o (qtick_w)
  );

  fbdiv_dualmod #(.PLOG_MIN(PLOG_MIN), .PSEL_W(PSEL_W)) u_dualmod (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_w),
    .tick_i  (qtick_w),
    .psel_i  (psel_sh_w),
    .hi_i    (hi_w),
    .ptick_o (ptick_w)
  );

  fbdiv_swallow #(.A_W(A_W), .B_W(B_W), .PSEL_W(PSEL_W)) u_swallow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_w),
    .ptick_i   (ptick_w),
    .psel_i    (psel_i),
    .a_i       (a_val_i),
    .b_i       (b_val_i),
    .hi_o      (hi_w),
    .reload_o  (reload_w),
    .psel_sh_o (psel_sh_w),
    .a_sh_o    (a_sh_w),
    .b_sh_o    (b_sh_w),
    .cfg_err_o (cfg_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= reload_w;
  end

  assign div_o = div_q;
endmodule

// File: rtl/fbdiv_chk.sv
module fbdiv_chk #(
  parameter int unsigned A_W     = fbdiv_pkg::A_W_DEF,
  parameter int unsigned B_W     = fbdiv_pkg::B_W_DEF,
  parameter int unsigned MIN_GAP = 4 * 2 * (1 << fbdiv_pkg::PLOG_MIN_DEF)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           hold_i,
  input logic           pdn_i,
  input logic [A_W-1:0] a_val_i,
  input logic [B_W-1:0] b_val_i,
  input logic           div_o,
  input logic           cfg_err_o,
  input logic           reload_w,
  input logic [A_W-1:0] a_sh_w,
  input logic [B_W-1:0] b_sh_w
);
  logic [15:0] gap_q;
  logic        bad_in;

  assign bad_in = (b_val_i < B_W'(2)) || (b_val_i < B_W'(a_val_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                gap_q <= '0;
    else if (div_o)             gap_q <= '0;
    else if (gap_q != 16'hffff) gap_q <= gap_q + 16'd1;
  end

  a_r1_min_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |-> (gap_q >= 16'(MIN_GAP - 1)));
  a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i || pdn_i) |=> !div_o);
  a_r5_shadow_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload_w && !hold_i && !pdn_i) |=> ($stable(a_sh_w) && $stable(b_sh_w)));
  a_r6_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_in |=> cfg_err_o);
  a_r6_err_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_in |=> !cfg_err_o);
  a_r6_shadow_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_sh_w >= B_W'(2)) && (b_sh_w >= B_W'(a_sh_w)));
  a_r9_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);
endmodule

bind fb_swallow_div fbdiv_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hold_i    (hold_i),
  .pdn_i     (pdn_i),
  .a_val_i   (a_val_i),
  .b_val_i   (b_val_i),
  .div_o     (div_o),
  .cfg_err_o (cfg_err_o),
  .reload_w  (reload_w),
  .a_sh_w    (a_sh_w),
  .b_sh_w    (b_sh_w)
);

// File: tb/fb_swallow_div_tb.sv
`timescale 1ns/1ps
module fb_swallow_div_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hold_i = 1'b0;
  logic        pdn_i = 1'b0;
  logic [1:0]  psel_i = 2'd0;
  logic [5:0]  a_val_i = 6'd1;
  logic [12:0] b_val_i = 13'd3;
  logic        div_o, cfg_err_o;

  int nchk = 0;
  int nbad = 0;

  always #2 clk_i = ~clk_i;

  fb_swallow_div u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i), .pdn_i(pdn_i),
    .psel_i(psel_i), .a_val_i(a_val_i), .b_val_i(b_val_i),
    .div_o(div_o), .cfg_err_o(cfg_err_o)
  );

  function automatic int ratio(int ps, int a, int b);
    return 4 * (b * (8 << ps) + a);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic next_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!div_o && n < 20000);
  endtask

  task automatic set_cfg(int ps, int a, int b);
    psel_i  = 2'(ps);
    a_val_i = 6'(a);
    b_val_i = 13'(b);
  endtask

  task automatic run_cfg(int ps, int a, int b, string req);
    int n;
    int e;
    e = ratio(ps, a, b);
    @(negedge clk_i);
    hold_i = 1'b1;
    set_cfg(ps, a, b);
    repeat (2) @(negedge clk_i);
    hold_i = 1'b0;
    next_pulse(n);
    chk(n == e, {req, " first"}, n, e);
    next_pulse(n);
    chk(n == e, {req, " steady"}, n, e);
  endtask

  initial begin
    #800000;
    nbad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int n;
    int q;
    // R8: reset state, then default config drives first period
    repeat (3) @(negedge clk_i);
    chk(div_o == 1'b0, "R8 div_o in reset", int'(div_o), 0);
    chk(cfg_err_o == 1'b0, "R8 err in reset", int'(cfg_err_o), 0);
    rst_ni = 1'b1;
    next_pulse(n);
    chk(n == 64, "R8 first period from defaults", n, 64);
    // R9: single-cycle pulse
    @(negedge clk_i);
    chk(div_o == 1'b0, "R9 pulse width", int'(div_o), 0);
    next_pulse(n);
    chk(n == 99, "R1 period after default", n, 99);

    // R1 R2: sweep of prescaler select and small A/B
    for (int ps = 0; ps < 4; ps++)
      for (int b = 2; b <= 4; b++)
        for (int a = 0; a <= b && a <= 3; a++)
          run_cfg(ps, a, b, "R1 R2 sweep");

    // R7: contiguous ratios from P*(P-1) for P=8
    for (int k = 56; k <= 66; k++)
      run_cfg(0, k % 8, k / 8, "R7 contiguous");

    // R5: change mid-run applies at the next boundary
    run_cfg(0, 1, 3, "R5 base");
    set_cfg(0, 0, 5);
    next_pulse(n);
    chk(n == 100, "R5 old period completes", n, 100);
    next_pulse(n);
    chk(n == 160, "R5 new period", n, 160);
    set_cfg(2, 3, 3);
    next_pulse(n);
    chk(n == 160, "R5 old period before psel change", n, 160);
    next_pulse(n);
    chk(n == ratio(2, 3, 3), "R5 new psel period", n, ratio(2, 3, 3));
    set_cfg(0, 0, 5);
    next_pulse(n);
    next_pulse(n);
    chk(n == 160, "R5 back to base", n, 160);

    // R6: illegal values flagged and rejected
    set_cfg(0, 0, 1);
    @(negedge clk_i);
    chk(cfg_err_o == 1'b1, "R6 err on B<2", int'(cfg_err_o), 1);
    next_pulse(n);
    chk(n == 159, "R6 period kept B<2", n, 159);
    next_pulse(n);
    chk(n == 160, "R6 period still kept B<2", n, 160);
    set_cfg(0, 4, 3);
    @(negedge clk_i);
    chk(cfg_err_o == 1'b1, "R6 err on B<A", int'(cfg_err_o), 1);
    next_pulse(n);
    next_pulse(n);
    chk(n == 160, "R6 period kept B<A", n, 160);
    set_cfg(0, 2, 2);
    @(negedge clk_i);
    chk(cfg_err_o == 1'b0, "R6 err clears", int'(cfg_err_o), 0);
    next_pulse(n);
    chk(n == 159, "R6 last old period", n, 159);
    next_pulse(n);
    chk(n == 72, "R6 legal value taken", n, 72);

    // R3: hold mid-period, rewrite config while parked
    set_cfg(1, 2, 3);
    next_pulse(n);
    next_pulse(n);
    chk(n == 200, "R3 base period", n, 200);
    repeat (37) @(negedge clk_i);
    hold_i = 1'b1;
    set_cfg(0, 1, 3);
    q = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      if (div_o) q++;
    end
    chk(q == 0, "R3 no pulse while held", q, 0);
    hold_i = 1'b0;
    next_pulse(n);
    chk(n == 100, "R3 restart after hold", n, 100);

    // R4: power-down behaves the same
    repeat (51) @(negedge clk_i);
    pdn_i = 1'b1;
    set_cfg(3, 1, 2);
    q = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      if (div_o) q++;
    end
    chk(q == 0, "R4 no pulse in power-down", q, 0);
    pdn_i = 1'b0;
    next_pulse(n);
    chk(n == ratio(3, 1, 2), "R4 restart after power-down", n, ratio(3, 1, 2));
    next_pulse(n);
    chk(n == ratio(3, 1, 2), "R4 steady after power-down", n, ratio(3, 1, 2));

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule